// File: doc/BRIEF.md
# Sampled-Input Filtered Event Counter

This block counts pulses that arrive on an asynchronous external pin. The pin is first brought into the system clock domain by a two-flop synchronizer. It is then sampled at one of four selectable rates. A level filter accepts a new high or low level only after three consecutive samples agree. Each accepted transition becomes a one-cycle enable for an up counter.

The count enable is taken from the rising transitions, the falling transitions or both, as chosen by a mode input. The counter works as an event counter only while its 4-bit count-source select holds the code assigned to the external pin; no other mode bit is involved. A synchronous clear input zeroes the count. When the counter wraps past its top value, an overflow flag pulses for one cycle.

The filter has a cost. A level must last three sampling periods before it is accepted, so the fastest input that can be counted runs at one sixth of the sampling rate. This limit applies in every edge mode.

Top module: `evt_filter_counter`

## Requirements
- R1: `samp_sel` picks the sampling rate. Code 0 samples on every system clock. Codes 1, 2 and 3 sample once every 32, 64 and 128 system clocks, so in those codes two sampling strobes never fall in adjacent cycles.
- R2: The filtered level and the edge pulses change only on a sampling strobe. The raw pin passes through two synchronizing flops before it is sampled.
- R3: A new filtered level is accepted only after three consecutive samples at that level. At the full rate, a pulse of 2 system clocks is never counted and a pulse of 3 system clocks is counted.
- R4: `edge_mode` selects which transitions are counted: 2'b00 counts rising edges only, 2'b01 counts falling edges only, and 2'b10 or 2'b11 count both.
- R5: Each accepted edge of the selected kind raises a one-cycle enable, and that enable adds exactly one to `count`.
- R6: While `clear` is high, `count` is set to zero on the next clock. Clear takes priority over an increment that falls in the same cycle.
- R7: The counter wraps from its all-ones value to zero. In that same update, `ovf` is high for exactly one cycle; at any other time it stays low.
- R8: The count advances only while `src_sel` equals 4'hE. With any other code, `count` holds its value whatever the pin does.
- R9: After reset, `count` is 0, `ovf` is 0 and the filtered level is low, so a high input must first pass three samples before it gives a rising edge.
- R10: An input of 3 sampling periods high followed by 3 low is counted without loss: one count per period in a single-edge mode, two per period in both-edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 1 | Asynchronous external event pin |
| samp_sel | input | 2 | Sampling rate select (full, /32, /64, /128) |
| edge_mode | input | 2 | Edge selection: rising, falling or both |
| src_sel | input | 4 | Count-source select; 4'hE selects the external pin |
| clear | input | 1 | Synchronous counter clear |
| count | output | 16 | Current counter value |
| ovf | output | 1 | One-cycle pulse when the counter wraps |

## Verification
Two functions can meet in one cycle: a filtered edge that wants to increment the counter, and a clear. The clear must win. The bench provokes this by holding `clear` high through a whole input pulse, so that the edge enable must arrive while clear is active. It then checks that the count reads zero both during the pulse and after clear drops. The second coincidence is a wrap that happens on an edge increment. A narrow instance is driven to its all-ones value and given one more pulse, and the bench checks that exactly one `ovf` pulse appears and the count lands on zero.

// File: rtl/efc_pkg.sv
// Package: shared types for the filtered event counter.
// Assumes: edge_mode codes are fixed by the external register layout.
package efc_pkg;
    typedef enum logic [1:0] {
        EDGE_RISE  = 2'b00,
        EDGE_FALL  = 2'b01,
        EDGE_BOTH  = 2'b10,
        EDGE_BOTH2 = 2'b11
    } edge_mode_t;
endpackage

// File: rtl/efc_sampler.sv
// Module: input synchronizer plus sampling prescaler.
// Produces the synchronized pin level and a one-cycle sample strobe.
// Assumes: the oscillator clock equals the system clock; code 0 strobes
// every cycle, code k>0 strobes once per 2**(BASE_SHIFT+k-1) cycles.
module efc_sampler #(
    parameter int BASE_SHIFT = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] samp_sel,
    output logic       samp,
    output logic       strobe
);
    localparam int PRE_W = BASE_SHIFT + 2;

    logic [1:0]       sync_q;
    logic [PRE_W-1:0] div_q;

    // Two-flop synchronizer for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], pin};
    end

    assign samp = sync_q[1];

    // Free-running prescaler counter.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // Strobe when the selected low bits of the prescaler are all ones.
    always_comb begin
        strobe = 1'b1;
        if (samp_sel != 2'd0) begin
            for (int i = 0; i < PRE_W; i++) begin
                if (i < BASE_SHIFT + int'(samp_sel) - 1 && !div_q[i])
                    strobe = 1'b0;
            end
        end
    end

    // R1: in a divided rate, strobes are never adjacent.
    p_strobe_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && samp_sel != 2'd0 && $stable(samp_sel)) |=> !strobe);
endmodule

// File: rtl/efc_filter.sv
// Module: three-sample level filter and edge detector.
// Keeps the last two samples; a level is accepted when the current sample
// and both stored ones agree. Emits one-cycle rise/fall pulses.
// Assumes: strobe is a one-cycle qualifier in the same clock domain.
module efc_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic samp,
    input  logic strobe,
    output logic level,
    output logic rise_p,
    output logic fall_p
);
    logic [1:0] hist_q;
    logic       level_q;
    logic       rise_q;
    logic       fall_q;

    // Shift samples on the strobe and update the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q  <= 2'b00;
            level_q <= 1'b0;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
            if (strobe) begin
                hist_q <= {hist_q[0], samp};
                if (!level_q && samp && hist_q == 2'b11) begin
                    level_q <= 1'b1;
                    rise_q  <= 1'b1;
                end else if (level_q && !samp && hist_q == 2'b00) begin
                    level_q <= 1'b0;
                    fall_q  <= 1'b1;
                end
            end
        end
    end

    assign level  = level_q;
    assign rise_p = rise_q;
    assign fall_p = fall_q;

    // R2: the accepted level changes only on a sampling strobe.
    p_level_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(level_q));
    // R3: a rising level follows three high samples.
    p_rise_three_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_q) |-> ($past(samp) && $past(hist_q) == 2'b11));
    // R3: a falling level follows three low samples.
    p_fall_three_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level_q) |-> (!$past(samp) && $past(hist_q) == 2'b00));
    // R5: edge pulses last one cycle.
    p_edge_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_q || fall_q) |=> !(rise_q || fall_q));
endmodule

// File: rtl/efc_counter.sv
// Module: up counter with synchronous clear and wrap flag.
// Clear has priority over the increment enable.
// Assumes: inc is a one-cycle pulse per event.
module efc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    // Count, clear and flag the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (clear) begin
                cnt_q <= '0;
            end else if (inc) begin
                cnt_q <= cnt_q + 1'b1;
                ovf_q <= (cnt_q == TOP);
            end
        end
    end

    assign count = cnt_q;
    assign ovf   = ovf_q;

    // R5: an enable adds exactly one.
    p_inc_by_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R6: clear zeroes the count, even with a coincident enable.
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0 && !ovf_q));
    // R7: wrap lands on zero with the flag raised.
    p_wrap_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear && cnt_q == TOP) |=> (ovf_q && cnt_q == '0));
    // R7: the flag only appears with a zero count.
    p_flag_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> cnt_q == '0);
    // R9: reset leaves the counter at zero.
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0 && !ovf_q));
endmodule

// File: rtl/evt_filter_counter.sv
// Module: top of the filtered event counter.
// Chains sampler, filter and counter; picks edges by mode and gates the
// count on the source select.
// Assumes: configuration inputs are quasi-static, driven by a register block.
module evt_filter_counter #(
    parameter int          CNT_W      = 16,
    parameter int          BASE_SHIFT = 5,
    parameter logic [3:0]  EXT_SRC    = 4'hE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_in,
    input  logic [1:0]       samp_sel,
    input  logic [1:0]       edge_mode,
    input  logic [3:0]       src_sel,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    import efc_pkg::*;

    logic       samp;
    logic       strobe;
    logic       level;
    logic       rise_p;
    logic       fall_p;
    logic       edge_hit;
    logic       inc;
    edge_mode_t mode;

    assign mode = edge_mode_t'(edge_mode);

    efc_sampler #(.BASE_SHIFT(BASE_SHIFT)) u_sampler (
        .clk(clk), .rst_n(rst_n), .pin(evt_in), .samp_sel(samp_sel),
        .samp(samp), .strobe(strobe)
    );

    efc_filter u_filter (
        .clk(clk), .rst_n(rst_n), .samp(samp), .strobe(strobe),
        .level(level), .rise_p(rise_p), .fall_p(fall_p)
    );

    // Select which filtered edges count.
    always_comb begin
        unique case (mode)
            EDGE_RISE: edge_hit = rise_p;
            EDGE_FALL: edge_hit = fall_p;
            default:   edge_hit = rise_p | fall_p;
        endcase
    end

    // Gate counting on the external source select.
    assign inc = edge_hit && (src_sel == EXT_SRC);

    efc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .inc(inc), .clear(clear),
        .count(count), .ovf(ovf)
    );

    // R8: with another source selected the count holds.
    p_src_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel != EXT_SRC && !clear) |=> $stable(count));
    // R4: rising-only mode ignores falling edges.
    p_rise_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EDGE_RISE && fall_p && !clear) |=> $stable(count));
    // R9: filtered level starts low after reset.
    p_level_reset_r9: assert property (@(posedge clk)
        !rst_n |=> !level);
endmodule

// File: tb/evt_filter_counter_test.sv
module evt_filter_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_in = 1'b0;
    logic [1:0]  samp_sel = 2'd0;
    logic [1:0]  edge_mode = 2'b00;
    logic [3:0]  src_sel = 4'hE;
    logic        clear = 1'b0;
    logic [15:0] count;
    logic        ovf;
    logic [3:0]  count_s;
    logic        ovf_s;

    int n_chk = 0;
    int n_fail = 0;
    int ovf_seen_s = 0;
    int ovf_seen_b = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evt_filter_counter uut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .samp_sel(samp_sel),
        .edge_mode(edge_mode), .src_sel(src_sel), .clear(clear),
        .count(count), .ovf(ovf)
    );

    evt_filter_counter #(.CNT_W(4)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .samp_sel(samp_sel),
        .edge_mode(edge_mode), .src_sel(src_sel), .clear(clear),
        .count(count_s), .ovf(ovf_s)
    );

    // Count overflow pulses away from the active edge.
    always @(negedge clk) begin
        if (ovf_s) ovf_seen_s++;
        if (ovf)   ovf_seen_b++;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(int hi, int lo);
        evt_in = 1'b1;
        tick(hi);
        evt_in = 1'b0;
        tick(lo);
    endtask

    task automatic t_reset;
        chk("R9 count after reset", int'(count), 0);
        chk("R9 ovf after reset", int'(ovf), 0);
        // A 2-cycle high right after reset must not give a rising edge.
        pulse(2, 10);
        chk("R9 no edge before three samples", int'(count), 0);
    endtask

    task automatic t_rising;
        int base = int'(count);
        edge_mode = 2'b00;
        for (int i = 0; i < 4; i++) pulse(5, 5);
        tick(10);
        chk("R4 R5 rising only", int'(count), base + 4);
    endtask

    task automatic t_falling;
        int base = int'(count);
        edge_mode = 2'b01;
        for (int i = 0; i < 3; i++) pulse(5, 5);
        tick(10);
        chk("R4 falling only", int'(count), base + 3);
    endtask

    task automatic t_both;
        int base = int'(count);
        edge_mode = 2'b10;
        for (int i = 0; i < 3; i++) pulse(5, 5);
        tick(10);
        chk("R4 both edges", int'(count), base + 6);
        base = int'(count);
        edge_mode = 2'b11;
        pulse(5, 10);
        chk("R4 both edges alt code", int'(count), base + 2);
    endtask

    task automatic t_glitch;
        int base;
        edge_mode = 2'b00;
        base = int'(count);
        for (int i = 0; i < 3; i++) pulse(2, 8);
        chk("R3 two-cycle pulse dropped", int'(count), base);
        pulse(3, 10);
        chk("R3 three-cycle pulse counted", int'(count), base + 1);
    endtask

    task automatic t_max_rate;
        int base = int'(count);
        edge_mode = 2'b10;
        for (int i = 0; i < 10; i++) pulse(3, 3);
        tick(10);
        chk("R10 sixth-rate both edges", int'(count), base + 20);
        base = int'(count);
        edge_mode = 2'b00;
        for (int i = 0; i < 10; i++) pulse(3, 3);
        tick(10);
        chk("R10 sixth-rate rising", int'(count), base + 10);
    endtask

    task automatic t_divided;
        int base;
        edge_mode = 2'b00;
        samp_sel = 2'd1;
        base = int'(count);
        pulse(40, 200);
        chk("R1 div32 short pulse dropped", int'(count), base);
        pulse(130, 200);
        chk("R1 div32 long pulse counted", int'(count), base + 1);
        samp_sel = 2'd3;
        base = int'(count);
        pulse(250, 600);
        chk("R1 div128 short pulse dropped", int'(count), base);
        pulse(520, 600);
        chk("R1 div128 long pulse counted", int'(count), base + 1);
        samp_sel = 2'd0;
        tick(10);
    endtask

    task automatic t_source;
        int base = int'(count);
        edge_mode = 2'b10;
        src_sel = 4'h3;
        for (int i = 0; i < 2; i++) pulse(5, 5);
        tick(10);
        chk("R8 other source holds", int'(count), base);
        src_sel = 4'hE;
        tick(10);
        chk("R8 no late count after reselect", int'(count), base);
        pulse(5, 10);
        chk("R8 counting resumes", int'(count), base + 2);
    endtask

    task automatic t_clear;
        edge_mode = 2'b00;
        clear = 1'b1;
        tick(1);
        chk("R6 clear zeroes", int'(count), 0);
        // Edge arrives while clear is held: clear must win.
        evt_in = 1'b1;
        tick(8);
        chk("R6 clear beats edge", int'(count), 0);
        evt_in = 1'b0;
        tick(8);
        clear = 1'b0;
        tick(5);
        chk("R6 no edge after clear", int'(count), 0);
    endtask

    task automatic t_wrap;
        edge_mode = 2'b00;
        clear = 1'b1;
        tick(1);
        clear = 1'b0;
        ovf_seen_s = 0;
        ovf_seen_b = 0;
        for (int i = 0; i < 15; i++) pulse(5, 5);
        tick(5);
        chk("R7 narrow at top", int'(count_s), 15);
        chk("R7 no flag before wrap", ovf_seen_s, 0);
        pulse(5, 10);
        chk("R7 narrow wrapped to zero", int'(count_s), 0);
        chk("R7 one flag pulse", ovf_seen_s, 1);
        chk("R5 wide count keeps going", int'(count), 16);
        chk("R7 wide no flag", ovf_seen_b, 0);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_rising();
        t_falling();
        t_both();
        t_glitch();
        t_max_rate();
        t_divided();
        t_source();
        t_clear();
        t_wrap();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule